// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Processor

A compact 32-bit processor core that finishes every instruction within a single clock period. On each rising edge it updates the program counter, and at most one of the register file or the data memory, from a purely combinational path. That path runs through instruction fetch, register read, the ALU, the data-memory read and the write-back select. Instruction storage and data storage are separate word arrays, so a fetch and a data access never compete. The instruction store has no write path in the design and is filled from the testbench. The data store is loaded the same way and is also written by store instructions.

The supported operations are word load and store, add, subtract, bitwise and, bitwise or, signed set-less-than, branch-if-equal and an absolute jump. Decoding happens in two steps. A main decoder turns the 6-bit opcode into control lines and an operation class. A second stage combines that class with the function field to pick the 3-bit ALU operation. A third, read-only register port is brought out to the pins so that architectural state can be inspected.

Top module: `sc_proc`

## Requirements
- R1: While `rst_ni` is low, the program counter is 0 and all 32 registers read 0. The first rising edge after release executes the instruction at byte address 0 (word 0).
- R2: An instruction with opcode 0 (bits 31:26) writes to register rd (bits 15:11) using rs (25:21) and rt (20:16). The function field (5:0) selects the operation: 0x20 gives rs+rt, 0x22 gives rs-rt, 0x24 gives rs AND rt, 0x25 gives rs OR rt, and 0x2A gives 1 when rs<rt as signed values and 0 otherwise.
- R3: Register 0 always reads 0 on every port, and any write addressed to it is dropped.
- R4: Opcode 35 loads the data word at rs + sext(imm16) into rt. Opcode 43 stores rt to that address. The word index is address bits above bit 1, the store takes effect on the clock edge, and the read is combinational.
- R5: Opcode 4 compares rs with rt. When they are equal, the next PC is PC+4 + (sext(imm16) << 2), and a negative offset moves backwards. When they differ, or for any instruction other than a branch or jump, the next PC is PC+4.
- R6: Opcode 2 sets the next PC to {(PC+4)[31:28], target[25:0], 2'b00}.
- R7: An unknown opcode, or opcode 0 with a function value not listed in R2, changes neither registers nor data memory, and the PC advances by 4.
- R8: `dbg_data_o` combinationally shows the register selected by `dbg_sel_i`.
- R9: The 16-bit immediate is sign-extended, so a negative offset in a load or store addresses below the base register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dbg_sel_i | input | 5 | Register number for the inspection port |
| dbg_data_o | output | 32 | Contents of the selected register |

## Verification
The bench instantiates the core with a 32-word instruction store and a 16-word data store. With that size the whole test program fills the instruction space exactly, and the final self-branch sits at the last word. The small data store keeps the load and store addresses, including one reached with a negative offset from a base register, inside a range that the bench seeds and predicts in full. The program includes a skipped forward branch, a taken forward branch, a backward branch, jumps, unsupported encodings and a write to register 0. The bench then reads the outcome back through the inspection port, and a second reset mid-run confirms the restart from word 0.

// File: rtl/sc_proc_pkg.sv
package sc_proc_pkg;
  localparam int XLEN = 32;
  localparam int NREGS = 32;
  localparam int RIDX = $clog2(NREGS);

  localparam logic [5:0] OPC_REG   = 6'd0;
  localparam logic [5:0] OPC_JMP   = 6'd2;
  localparam logic [5:0] OPC_BEQ   = 6'd4;
  localparam logic [5:0] OPC_LOAD  = 6'd35;
  localparam logic [5:0] OPC_STORE = 6'd43;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_SUB = 3'b110,
    ALU_SLT = 3'b111
  } alu_op_e;

  typedef enum logic [1:0] {
    CLS_ADDR = 2'b00,
    CLS_CMP  = 2'b01,
    CLS_FUNC = 2'b10
  } alu_cls_e;

  typedef struct packed {
    logic    dst_rd;
    logic    use_imm;
    logic    wb_mem;
    logic    reg_write;
    logic    mem_write;
    logic    branch;
    logic    jump;
    alu_op_e alu_op;
  } ctrl_t;
endpackage

// File: rtl/sc_ctrl.sv
module sc_ctrl
  import sc_proc_pkg::*;
(
  input  logic [5:0] op_i,
  input  logic [5:0] funct_i,
  output ctrl_t      ctrl_o
);
  alu_cls_e cls;
  alu_op_e  alu_op;
  logic     fn_bad;
  logic     dst_rd, use_imm, wb_mem, wr_req, mem_write, branch, jump;

  // first level: opcode to control lines and operation class
  always_comb begin
    cls       = CLS_ADDR;
    dst_rd    = 1'b0;
    use_imm   = 1'b0;
    wb_mem    = 1'b0;
    wr_req    = 1'b0;
    mem_write = 1'b0;
    branch    = 1'b0;
    jump      = 1'b0;
    case (op_i)
      OPC_REG: begin
        cls    = CLS_FUNC;
        dst_rd = 1'b1;
        wr_req = 1'b1;
      end
      OPC_LOAD: begin
        use_imm = 1'b1;
        wb_mem  = 1'b1;
        wr_req  = 1'b1;
      end
      OPC_STORE: begin
        use_imm   = 1'b1;
        mem_write = 1'b1;
      end
      OPC_BEQ: begin
        cls    = CLS_CMP;
        branch = 1'b1;
      end
      OPC_JMP: jump = 1'b1;
      default: ;
    endcase
  end

  // second level: class plus function field to ALU operation
  always_comb begin
    fn_bad = 1'b0;
    alu_op = ALU_ADD;
    case (cls)
      CLS_ADDR: alu_op = ALU_ADD;
      CLS_CMP:  alu_op = ALU_SUB;
      CLS_FUNC: begin
        case (funct_i)
          FN_ADD:  alu_op = ALU_ADD;
          FN_SUB:  alu_op = ALU_SUB;
          FN_AND:  alu_op = ALU_AND;
          FN_OR:   alu_op = ALU_OR;
          FN_SLT:  alu_op = ALU_SLT;
          default: fn_bad = 1'b1;
        endcase
      end
      default: alu_op = ALU_ADD;
    endcase
  end

  always_comb begin
    ctrl_o.dst_rd    = dst_rd;
    ctrl_o.use_imm   = use_imm;
    ctrl_o.wb_mem    = wb_mem;
    ctrl_o.reg_write = wr_req & ~fn_bad;
    ctrl_o.mem_write = mem_write;
    ctrl_o.branch    = branch;
    ctrl_o.jump      = jump;
    ctrl_o.alu_op    = alu_op;
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_proc_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  alu_op_e      op_i,
  output logic [W-1:0] y_o,
  output logic         zero_o
);
  always_comb begin
    case (op_i)
      ALU_AND: y_o = a_i & b_i;
      ALU_OR:  y_o = a_i | b_i;
      ALU_ADD: y_o = a_i + b_i;
      ALU_SUB: y_o = a_i - b_i;
      ALU_SLT: y_o = {{(W-1){1'b0}}, ($signed(a_i) < $signed(b_i))};
      default: y_o = a_i + b_i;
    endcase
  end

  assign zero_o = (y_o == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile
  import sc_proc_pkg::*;
#(
  parameter int N = NREGS,
  parameter int W = XLEN,
  localparam int AW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] ra_a_i,
  input  logic [AW-1:0] ra_b_i,
  input  logic [AW-1:0] ra_d_i,
  output logic [W-1:0]  rd_a_o,
  output logic [W-1:0]  rd_b_o,
  output logic [W-1:0]  rd_d_o,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [W-1:0]  wd_i
);
  logic [W-1:0] regs_q [N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) regs_q[i] <= '0;
    end else if (we_i && (wa_i != '0)) begin
      regs_q[wa_i] <= wd_i;
    end
  end

  assign rd_a_o = (ra_a_i == '0) ? '0 : regs_q[ra_a_i];
  assign rd_b_o = (ra_b_i == '0) ? '0 : regs_q[ra_b_i];
  assign rd_d_o = (ra_d_i == '0) ? '0 : regs_q[ra_d_i];

  p_wr_lands_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_ni && we_i && (wa_i != '0)) |=> (regs_q[$past(wa_i)] == $past(wd_i)));

  p_r0_read_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ra_d_i == '0) |-> (rd_d_o == '0));
endmodule

// File: rtl/sc_mem.sv
module sc_mem
  import sc_proc_pkg::*;
#(
  parameter int WORDS = 64,
  parameter bit WRITABLE = 1'b1,
  localparam int AW = $clog2(WORDS)
) (
  input  logic            clk_i,
  input  logic            we_i,
  input  logic [XLEN-1:0] addr_i,
  input  logic [XLEN-1:0] wdata_i,
  output logic [XLEN-1:0] rdata_o
);
  logic [XLEN-1:0] mem_q [WORDS];
  logic [AW-1:0]   idx;
  logic            unused_addr;

  assign idx         = addr_i[AW+1:2];
  assign unused_addr = ^{addr_i[XLEN-1:AW+2], addr_i[1:0]};
  assign rdata_o     = mem_q[idx];

  if (WRITABLE) begin : g_rw
    always_ff @(posedge clk_i) begin
      if (we_i) mem_q[idx] <= wdata_i;
    end

    p_store_r4: assert property (@(posedge clk_i)
      we_i |=> (mem_q[$past(idx)] == $past(wdata_i)));
  end else begin : g_ro
    logic unused_wr;
    assign unused_wr = ^{we_i, wdata_i, clk_i};
    initial begin
      for (int i = 0; i < WORDS; i++) mem_q[i] = '0;
    end
  end
endmodule

// File: rtl/sc_proc.sv
module sc_proc
  import sc_proc_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [RIDX-1:0] dbg_sel_i,
  output logic [XLEN-1:0] dbg_data_o
);
  logic [XLEN-1:0] pc_q, pc_next, pc_plus4, br_target, jmp_target;
  logic [XLEN-1:0] instr, imm_ext;
  logic [XLEN-1:0] rs_val, rt_val, alu_b, alu_y, mem_rdata, wb_data;
  logic [RIDX-1:0] wa;
  logic            alu_zero, take_br, unused_shamt;
  ctrl_t           ctl;

  assign unused_shamt = ^instr[10:6];

  sc_mem #(.WORDS(IMEM_WORDS), .WRITABLE(1'b0)) u_imem (
    .clk_i  (clk_i),
    .we_i   (1'b0),
    .addr_i (pc_q),
    .wdata_i('0),
    .rdata_o(instr)
  );

  sc_ctrl u_ctrl (
    .op_i   (instr[31:26]),
    .funct_i(instr[5:0]),
    .ctrl_o (ctl)
  );

  assign wa = ctl.dst_rd ? instr[15:11] : instr[20:16];

  sc_regfile u_rf (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ra_a_i(instr[25:21]),
    .ra_b_i(instr[20:16]),
    .ra_d_i(dbg_sel_i),
    .rd_a_o(rs_val),
    .rd_b_o(rt_val),
    .rd_d_o(dbg_data_o),
    .we_i  (ctl.reg_write),
    .wa_i  (wa),
    .wd_i  (wb_data)
  );

  assign imm_ext = {{(XLEN-16){instr[15]}}, instr[15:0]};
  assign alu_b   = ctl.use_imm ? imm_ext : rt_val;

  sc_alu u_alu (
    .a_i   (rs_val),
    .b_i   (alu_b),
    .op_i  (ctl.alu_op),
    .y_o   (alu_y),
    .zero_o(alu_zero)
  );

  sc_mem #(.WORDS(DMEM_WORDS), .WRITABLE(1'b1)) u_dmem (
    .clk_i  (clk_i),
    .we_i   (ctl.mem_write & rst_ni),
    .addr_i (alu_y),
    .wdata_i(rt_val),
    .rdata_o(mem_rdata)
  );

  assign wb_data = ctl.wb_mem ? mem_rdata : alu_y;

  // next PC: own adder for the branch target, independent of the ALU
  assign pc_plus4   = pc_q + 32'd4;
  assign br_target  = pc_plus4 + {imm_ext[XLEN-3:0], 2'b00};
  assign jmp_target = {pc_plus4[31:28], instr[25:0], 2'b00};
  assign take_br    = ctl.branch & alu_zero;

  always_comb begin
    if (ctl.jump)     pc_next = jmp_target;
    else if (take_br) pc_next = br_target;
    else              pc_next = pc_plus4;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_next;
  end

  p_seq_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_ni && !ctl.jump && !(ctl.branch && (rs_val == rt_val)))
      |=> (pc_q == $past(pc_q) + 32'd4));

  p_br_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_ni && ctl.branch && (rs_val == rt_val))
      |=> (pc_q == $past(pc_q) + 32'd4
                   + {{14{$past(instr[15])}}, $past(instr[15:0]), 2'b00}));

  p_jmp_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_ni && ctl.jump) |=> (pc_q[27:0] == {$past(instr[25:0]), 2'b00}));

  p_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ctl.reg_write, ctl.mem_write, ctl.branch, ctl.jump}));
endmodule

// File: tb/sim_sc_proc.sv
`timescale 1ns/100ps
module sim_sc_proc;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  dbg_sel = '0;
  logic [31:0] dbg_data;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  typedef struct {
    logic [4:0]  r;
    logic [31:0] v;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  always #2 clk = ~clk;

  sc_proc #(.IMEM_WORDS(32), .DMEM_WORDS(16)) u0 (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .dbg_sel_i (dbg_sel),
    .dbg_data_o(dbg_data)
  );

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction
  function automatic logic [31:0] enc_j(int tgt);
    return {6'd2, 26'(tgt)};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic push_exp(int r, logic [31:0] v, string tag);
    exp_t e;
    e.r = 5'(r); e.v = v; e.tag = tag;
    sb_q.push_back(e);
  endtask

  // monitor: pops expected items and compares through the inspection port
  task automatic monitor();
    while (sb_q.size() > 0) begin
      exp_t e = sb_q.pop_front();
      dbg_sel = e.r;
      #0.5;
      check(e.tag, dbg_data, e.v);
    end
  endtask

  initial begin
    logic [31:0] prog [32];
    for (int i = 0; i < 32; i++) prog[i] = 32'd0;
    prog[0]  = enc_i(6'd35, 0, 1, 16'd0);       // r1=5
    prog[1]  = enc_i(6'd35, 0, 2, 16'd4);       // r2=3
    prog[2]  = enc_i(6'd35, 0, 3, 16'd8);       // r3=-8
    prog[3]  = enc_r(1, 2, 4, 6'h20);
    prog[4]  = enc_r(1, 2, 5, 6'h22);
    prog[5]  = enc_r(1, 2, 6, 6'h24);
    prog[6]  = enc_r(1, 2, 7, 6'h25);
    prog[7]  = enc_r(3, 1, 8, 6'h2A);
    prog[8]  = enc_r(1, 3, 9, 6'h2A);
    prog[9]  = enc_r(1, 2, 0, 6'h20);           // write to r0
    prog[10] = enc_i(6'd43, 0, 4, 16'd16);      // d[4]=8
    prog[11] = enc_i(6'd35, 0, 10, 16'd16);
    prog[12] = enc_r(4, 4, 11, 6'h20);          // r11=16
    prog[13] = enc_i(6'd43, 4, 11, 16'hFFFC);   // d[1]=16 via 8-4
    prog[14] = enc_i(6'd35, 0, 12, 16'd4);
    prog[15] = enc_i(6'd4, 1, 2, 16'd1);        // not taken
    prog[16] = enc_r(1, 0, 13, 6'h20);
    prog[17] = enc_i(6'd4, 4, 10, 16'd2);       // taken -> 20
    prog[18] = enc_r(1, 1, 14, 6'h20);
    prog[19] = enc_r(2, 2, 14, 6'h20);
    prog[20] = enc_r(2, 0, 15, 6'h20);
    prog[21] = enc_j(24);
    prog[22] = enc_r(1, 1, 16, 6'h20);
    prog[23] = enc_r(1, 1, 16, 6'h20);
    prog[24] = enc_i(6'h3F, 1, 17, 16'd7);      // unknown opcode
    prog[25] = enc_r(1, 2, 18, 6'h01);          // unknown funct
    prog[26] = enc_j(30);
    prog[27] = enc_r(1, 0, 20, 6'h20);
    prog[28] = enc_j(31);
    prog[29] = enc_r(2, 2, 20, 6'h20);
    prog[30] = enc_i(6'd4, 0, 0, 16'hFFFC);     // back to 27
    prog[31] = enc_i(6'd4, 0, 0, 16'hFFFF);     // spin

    rst_ni = 1'b0;
    #1;
    for (int i = 0; i < 32; i++) u0.u_imem.mem_q[i] = prog[i];
    for (int i = 0; i < 16; i++) u0.u_dmem.mem_q[i] <= 32'd0;
    #0.1;
    u0.u_dmem.mem_q[0] <= 32'd5;
    u0.u_dmem.mem_q[1] <= 32'd3;
    u0.u_dmem.mem_q[2] <= 32'hFFFF_FFF8;

    push_exp(0, 32'd0, "R1 reset r0");
    push_exp(1, 32'd0, "R1 reset r1");
    push_exp(5, 32'd0, "R1 reset r5");
    push_exp(31, 32'd0, "R1 reset r31");
    monitor();

    @(negedge clk);
    rst_ni = 1'b1;
    repeat (60) @(negedge clk);

    push_exp(1, 32'd5, "R4 load word0");
    push_exp(2, 32'd3, "R4 load word1");
    push_exp(3, 32'hFFFF_FFF8, "R4 load word2");
    push_exp(4, 32'd8, "R2 add");
    push_exp(5, 32'd2, "R2 sub");
    push_exp(6, 32'd1, "R2 and");
    push_exp(7, 32'd7, "R2 or");
    push_exp(8, 32'd1, "R2 slt signed true");
    push_exp(9, 32'd0, "R2 slt signed false");
    push_exp(0, 32'd0, "R3 r0 write dropped");
    push_exp(10, 32'd8, "R4 store then load");
    push_exp(11, 32'd16, "R8 debug read r11");
    push_exp(12, 32'd16, "R9 negative store offset");
    push_exp(13, 32'd5, "R5 untaken branch falls through");
    push_exp(14, 32'd0, "R5 taken branch skips");
    push_exp(15, 32'd3, "R5 branch target executes");
    push_exp(16, 32'd0, "R6 jump skips");
    push_exp(17, 32'd0, "R7 unknown opcode");
    push_exp(18, 32'd0, "R7 unknown funct");
    push_exp(20, 32'd5, "R5 backward branch");
    monitor();

    @(negedge clk);
    rst_ni = 1'b0;
    push_exp(4, 32'd0, "R1 async clear");
    monitor();
    @(negedge clk);
    rst_ni = 1'b1;
    @(posedge clk);
    #1;
    push_exp(1, 32'd5, "R1 restart word0");
    push_exp(2, 32'd0, "R1 only one instruction");
    monitor();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule